// File: doc/BRIEF.md
# Watchdog Timer with Guarded Turn-Off

This block is a watchdog for a system-clock domain. It counts strobes on a separate watchdog tick input. When the number of counted ticks reaches the interval chosen by a three-bit select code, it drives a reset request for exactly one system-clock cycle. Software keeps the system alive by pulsing a kick input, which starts the count again from zero.

Configuration arrives through a single-cycle write strobe that carries three fields: an enable bit, an unlock bit and an interval code. Turning the watchdog on takes effect at once. Turning it off is guarded against stray writes. One write must first set the unlock bit and the enable bit together, and this opens a short window. A write that clears enable is accepted only while that window is open. At any other time such a write is dropped completely.

Top module: `wdt_top`

## Requirements
- R1: After reset the watchdog is off, the interval code is 0 and `wdt_reset` is low. While it stays off, ticks never cause a pulse.
- R2: While enabled with interval code c (0..7), `wdt_reset` goes high in the cycle after the clock edge that samples the 2^(BASE_EXP+c)-th tick counted since the last restart. The default BASE_EXP is 14. Tick spacing does not change this count.
- R3: Each timeout pulse on `wdt_reset` lasts exactly one clock cycle. After the pulse the count starts again from zero.
- R4: A `kick` strobe clears the tick count to zero. A tick sampled in the same cycle as a kick is not counted.
- R5: A write with `cfg_enable`=1 turns the watchdog on in that cycle, loads `cfg_interval` and restarts the count from zero. No preceding sequence is needed, including right after the watchdog was turned off.
- R6: A write with `cfg_enable`=0 while no unlock window is open is ignored. The on/off state, the interval and the running count all stay unchanged.
- R7: A write with `cfg_enable`=1 and `cfg_unlock`=1 opens an unlock window. A write with `cfg_enable`=0 sampled on any of the next UNLOCK_WINDOW (default 4) clock edges turns the watchdog off, and it then produces no pulse.
- R8: After those UNLOCK_WINDOW edges the window closes by itself. A later write with `cfg_enable`=0 is ignored as in R6.
- R9: While the watchdog is off, its count is held at zero and `wdt_reset` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Single-cycle configuration write strobe |
| cfg_enable | input | 1 | Enable field of the write |
| cfg_unlock | input | 1 | Unlock field; opens the turn-off window when written together with enable=1 |
| cfg_interval | input | 3 | Interval code c; timeout after 2^(BASE_EXP+c) ticks |
| kick | input | 1 | Restart strobe from software |
| wd_tick | input | 1 | Watchdog tick strobe, one per counted tick |
| wdt_reset | output | 1 | One-cycle reset request on timeout |

## Verification
The timeout pulse is the only window into the internal state. A wrong count, a wrong interval or a wrong on/off state therefore shows up as a pulse that arrives on the wrong tick, or that arrives when none should. A count the wrong way round or an ignored write that was wrongly taken shifts the pulse by a known number of ticks within one interval. The bench runs with a small BASE_EXP so that every interval code is exercised. A window that is one cycle too long or too short is exposed by a turn-off write placed on the last edge of the window and by one placed on the first edge after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SEL_W = 3;

    // One configuration write as seen by the control logic
    typedef struct packed {
        logic             enable;
        logic             unlock;
        logic [SEL_W-1:0] sel;
    } wdt_wr_t;

    // How the control logic treats the write in the current cycle
    typedef enum logic [1:0] {
        WR_NONE,
        WR_ENABLE,
        WR_DISARM,
        WR_DROPPED
    } wr_kind_e;

    // Final count value before timeout: 2^(base+sel) - 1
    function automatic logic [31:0] last_count(input int base, input logic [SEL_W-1:0] sel);
        return (32'd1 << (base + int'(sel))) - 32'd1;
    endfunction

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int UNLOCK_WINDOW = 4,
    localparam int WIN_W = $clog2(UNLOCK_WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  wdt_wr_t          wr,
    output logic             run,
    output logic [SEL_W-1:0] sel,
    output logic [WIN_W-1:0] win,
    output logic             restart
);

    wr_kind_e         kind;
    logic [WIN_W-1:0] win_next;

    always_comb begin
        if (!wr_en)
            kind = WR_NONE;
        else if (wr.enable)
            kind = WR_ENABLE;
        else if (win != '0)
            kind = WR_DISARM;
        else
            kind = WR_DROPPED;
        restart  = (kind == WR_ENABLE) || (kind == WR_DISARM);
        win_next = (win != '0) ? win - 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            sel <= '0;
            win <= '0;
        end else begin
            unique case (kind)
                WR_ENABLE: begin
                    run <= 1'b1;
                    sel <= wr.sel;
                    win <= wr.unlock ? WIN_W'(UNLOCK_WINDOW) : win_next;
                end
                WR_DISARM: begin
                    run <= 1'b0;
                    sel <= wr.sel;
                    win <= '0;
                end
                default: win <= win_next;
            endcase
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 14,
    localparam int CW = BASE_EXP + 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic [CW-1:0]    cnt,
    output logic             fire
);

    logic [31:0] last_full;
    logic        at_last;

    always_comb begin
        last_full = last_count(BASE_EXP, sel);
        at_last   = (cnt == last_full[CW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!run || clear) begin
                cnt <= '0;
            end else if (tick) begin
                if (at_last) begin
                    cnt  <= '0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int BASE_EXP      = 14,
    parameter int UNLOCK_WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       cfg_enable,
    input  logic       cfg_unlock,
    input  logic [2:0] cfg_interval,
    input  logic       kick,
    input  logic       wd_tick,
    output logic       wdt_reset
);

    localparam int CW    = BASE_EXP + 7;
    localparam int WIN_W = $clog2(UNLOCK_WINDOW + 1);

    wdt_wr_t          wr;
    logic             run;
    logic [SEL_W-1:0] sel;
    logic [WIN_W-1:0] win;
    logic             restart;
    logic             clear;
    logic [CW-1:0]    cnt;

    assign wr    = '{enable: cfg_enable, unlock: cfg_unlock, sel: cfg_interval};
    assign clear = kick | restart;

    wdt_ctrl #(.UNLOCK_WINDOW(UNLOCK_WINDOW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr      (wr),
        .run     (run),
        .sel     (sel),
        .win     (win),
        .restart (restart)
    );

    wdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .clear (clear),
        .tick  (wd_tick),
        .sel   (sel),
        .cnt   (cnt),
        .fire  (wdt_reset)
    );

endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk #(
    parameter int BASE_EXP      = 14,
    parameter int UNLOCK_WINDOW = 4,
    localparam int CW    = BASE_EXP + 7,
    localparam int WIN_W = $clog2(UNLOCK_WINDOW + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic             cfg_enable,
    input logic             cfg_unlock,
    input logic             kick,
    input logic             wdt_reset,
    input logic             run,
    input logic [WIN_W-1:0] win,
    input logic [CW-1:0]    cnt
);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |=> !wdt_reset);

    a_r9_pulse_needs_run: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> $past(run));

    a_r9_count_idle_off: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    a_r4_kick_clears: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == '0) && !wdt_reset);

    a_r5_enable_now: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_enable) |=> run && (cnt == '0));

    a_r6_dropped_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_enable && (win == '0)) |=> (run == $past(run)));

    a_r7_window_opens: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_enable && cfg_unlock) |=> (win == WIN_W'(UNLOCK_WINDOW)));

    a_r8_window_drains: assert property (@(posedge clk) disable iff (rst)
        ((win != '0) && !cfg_wr) |=> (win == $past(win) - 1'b1));

endmodule

bind wdt_top wdt_top_chk #(.BASE_EXP(BASE_EXP), .UNLOCK_WINDOW(UNLOCK_WINDOW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_enable (cfg_enable),
    .cfg_unlock (cfg_unlock),
    .kick       (kick),
    .wdt_reset  (wdt_reset),
    .run        (run),
    .win        (win),
    .cnt        (cnt)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;

    localparam int BASE = 4;
    localparam int NV   = 6;
    localparam int VCODE [NV] = '{0, 1, 2, 3, 5, 7};
    localparam int VGAP  [NV] = '{1, 2, 1, 3, 1, 1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_unlock = 1'b0;
    logic [2:0] cfg_interval = 3'd0;
    logic       kick = 1'b0;
    logic       wd_tick = 1'b0;
    logic       wdt_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_top #(.BASE_EXP(BASE), .UNLOCK_WINDOW(4)) dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_enable   (cfg_enable),
        .cfg_unlock   (cfg_unlock),
        .cfg_interval (cfg_interval),
        .kick         (kick),
        .wd_tick      (wd_tick),
        .wdt_reset    (wdt_reset)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; drives one write and returns at the next negedge
    task automatic write_ctl(input bit en, input bit unl, input int code);
        cfg_wr = 1'b1;
        cfg_enable = en;
        cfg_unlock = unl;
        cfg_interval = 3'(code);
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_enable = 1'b0;
        cfg_unlock = 1'b0;
    endtask

    // Apply up to maxn ticks spaced gap cycles apart; n = tick that produced a pulse
    task automatic tick_until(input int maxn, input int gap, output int n, output bit seen);
        seen = 1'b0;
        n = 0;
        for (int i = 1; i <= maxn && !seen; i++) begin
            wd_tick = 1'b1;
            @(negedge clk);
            wd_tick = 1'b0;
            if (wdt_reset) begin
                seen = 1'b1;
                n = i;
                @(negedge clk);
                check(wdt_reset == 1'b0, "R3 pulse width", int'(wdt_reset), 0);
            end else begin
                for (int g = 1; g < gap && !seen; g++) begin
                    @(negedge clk);
                    if (wdt_reset) begin
                        seen = 1'b1;
                        n = -i;
                    end
                end
            end
        end
    endtask

    initial begin
        int  n;
        bit  seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, watchdog off
        check(wdt_reset == 1'b0, "R1 pulse low after reset", int'(wdt_reset), 0);
        tick_until(40, 1, n, seen);
        check(!seen, "R1 off after reset, no pulse", n, 0);

        // R2: table of interval codes and tick spacings
        for (int v = 0; v < NV; v++) begin
            write_ctl(1'b1, 1'b0, VCODE[v]);
            tick_until(3000, VGAP[v], n, seen);
            check(seen && n == (1 << (BASE + VCODE[v])), "R2 timeout tick count",
                  n, 1 << (BASE + VCODE[v]));
        end

        // R4: kick clears count; tick in kick cycle not counted
        write_ctl(1'b1, 1'b0, 0);
        tick_until(10, 1, n, seen);
        check(!seen, "R4 no pulse before kick", n, 0);
        kick = 1'b1;
        wd_tick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        wd_tick = 1'b0;
        tick_until(40, 1, n, seen);
        check(seen && n == 16, "R4 count after kick", n, 16);

        // R5: enable write restarts count
        write_ctl(1'b1, 1'b0, 0);
        tick_until(10, 1, n, seen);
        write_ctl(1'b1, 1'b0, 0);
        tick_until(40, 1, n, seen);
        check(seen && n == 16, "R5 restart by enable write", n, 16);

        // R6: plain disable ignored, count and interval kept
        write_ctl(1'b1, 1'b0, 0);
        tick_until(5, 1, n, seen);
        write_ctl(1'b0, 1'b0, 3);
        tick_until(200, 1, n, seen);
        check(seen && n == 11, "R6 dropped write keeps count", n, 11);

        // R7: disarm on each edge of the window; R9: no pulse while off
        for (int d = 1; d <= 4; d++) begin
            write_ctl(1'b1, 1'b0, 0);
            write_ctl(1'b1, 1'b1, 0);
            repeat (d - 1) @(negedge clk);
            write_ctl(1'b0, 1'b0, 0);
            tick_until(40, 1, n, seen);
            check(!seen, "R7 R9 disarmed in window", n, 0);
        end

        // R5: re-enable without sequence after disarm
        write_ctl(1'b1, 1'b0, 1);
        tick_until(100, 1, n, seen);
        check(seen && n == 32, "R5 re-enable after disarm", n, 32);

        // R8: window expired, disable write ignored
        write_ctl(1'b1, 1'b1, 0);
        repeat (4) @(negedge clk);
        write_ctl(1'b0, 1'b0, 0);
        tick_until(40, 1, n, seen);
        check(seen && n == 16, "R8 late disable ignored", n, 16);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule